// File: doc/BRIEF.md
# Counting Level-Sensitive Interrupt Controller

This block gathers a parameterised number of level-sensitive request lines (64 by default) into one upstream interrupt. Each line has its own enable bit. The controller keeps a running tally of the lines that are both high and enabled. The upstream interrupt is raised whenever that tally is non-zero.

Software works through a small word-addressed register port inside a 4 KiB window. It can read an identification word, the tally, and the index of the lowest-numbered active line. It turns single lines on or off by writing a line number, and it can switch every line off with one write.

The line levels are sampled on every clock. A rise or fall on an enabled line moves the tally by one. When a level change and a register write fall in the same clock, their effects are merged into one net update.

Top module: `irq_tally_ctrl`

## Requirements
- R1: `irq_out` is registered and is high exactly when the pending tally is non-zero; it changes on the same clock edge as the tally.
- R2: A line level that rises on an enabled line adds one to the tally, and a fall on an enabled line removes one. Level changes on disabled lines leave the tally alone. The tally is read at word 1 (byte offset 0x04).
- R3: A read of word 2 (byte offset 0x08) returns the lowest index whose line is high and enabled, or 0xFFFFFFFF when no line is active.
- R4: Writing a line index to word 5 (byte offset 0x14) enables a disabled line and adds one to the tally if that line is high. Writing the index of a line that is already enabled changes nothing.
- R5: Writing a line index to word 4 (byte offset 0x10) disables an enabled line and removes one from the tally if that line is high. The tally never wraps below zero.
- R6: Any write to word 3 (byte offset 0x0C) clears every enable bit, forces the tally to zero and drops `irq_out`.
- R7: Enable or disable writes whose full 32-bit value is at least NUM_LINES are ignored; they are not truncated to a valid index.
- R8: Word 0 reads the constant 0x1A7C0001. Reads of words 3 to 5 and of unmapped words return zero. Writes to words 0 to 2 and to unmapped words are ignored. Only address bits 11:2 select the word. Read data is registered and appears on `bus_rdata` the cycle after the read request.
- R9: After reset, all enables are clear, the tally is zero, `irq_out` is low and `bus_rdata` is zero.
- R10: A level change and an enable or disable write in the same clock produce a single net tally change equal to the change in the number of high-and-enabled lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | NUM_LINES | Level-sensitive request lines |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address; bits 11:2 select the word |
| bus_wdata | input | 32 | Write data (line index for enable/disable) |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Upstream interrupt, high while the tally is non-zero |

## Verification
The tally is driven by three kinds of stimulus, so that each source of change can be told apart from the others:
- Level changes on enabled and on disabled lines, which separate a gated count from a raw count of high lines.
- Enable and disable writes against lines that are high or low, and against lines already in the target state, which show whether the write path tests the line level and is idempotent.
- Out-of-range values chosen so that truncating them would hit a live line, which exposes any narrowing of the index.

Clocks in which a level edge coincides with an enable or disable write show whether the two updates are merged or one of them is lost. The lowest-index read is checked both with several lines active and with none active.

// File: rtl/irq_tally_pkg.sv
package irq_tally_pkg;
  localparam int WIN_W  = 12;
  localparam int WORD_W = WIN_W - 2;
  localparam int DATA_W = 32;

  localparam int W_IDENT      = 0;
  localparam int W_COUNT      = 1;
  localparam int W_FIRST      = 2;
  localparam int W_MASK_ALL   = 3;
  localparam int W_MASK_ONE   = 4;
  localparam int W_UNMASK_ONE = 5;

  localparam logic [DATA_W-1:0] TALLY_ID  = 32'h1A7C_0001;
  localparam logic [DATA_W-1:0] NONE_WORD = 32'hFFFF_FFFF;
endpackage

// File: rtl/irq_line_bank.sv
module irq_line_bank #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] irq_lines,
  input  logic [N-1:0] en_set,
  input  logic [N-1:0] en_clr,
  input  logic         clr_all,
  output logic [N-1:0] en_q,
  output logic [N-1:0] act_q,
  output logic [N-1:0] act_d
);
  logic [N-1:0] lvl_q;
  logic [N-1:0] en_d;

  for (genvar i = 0; i < N; i++) begin : g_line
    always_comb begin
      if (clr_all)        en_d[i] = 1'b0;
      else if (en_set[i]) en_d[i] = 1'b1;
      else if (en_clr[i]) en_d[i] = 1'b0;
      else                en_d[i] = en_q[i];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        lvl_q[i] <= 1'b0;
        en_q[i]  <= 1'b0;
      end else begin
        lvl_q[i] <= irq_lines[i];
        en_q[i]  <= en_d[i];
      end
    end

    assign act_q[i] = lvl_q[i] & en_q[i];
    assign act_d[i] = irq_lines[i] & en_d[i];
  end

  assert_all_clear_R6: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> (en_q == '0));
endmodule

// File: rtl/irq_pop_delta.sv
module irq_pop_delta #(
  parameter int N     = 64,
  parameter int CNT_W = 7
) (
  input  logic [N-1:0]     act_q,
  input  logic [N-1:0]     act_d,
  input  logic             clr_all,
  input  logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d
);
  function automatic logic [CNT_W-1:0] pop(input logic [N-1:0] v);
    logic [CNT_W-1:0] s;
    s = '0;
    for (int i = 0; i < N; i++) s = s + CNT_W'(v[i]);
    return s;
  endfunction

  logic [CNT_W-1:0] inc, dec;

  always_comb begin
    inc = pop(act_d & ~act_q);
    dec = pop(act_q & ~act_d);
    if (clr_all) cnt_d = '0;
    else         cnt_d = cnt_q + inc - dec;
  end
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int N     = 64,
  parameter int IDX_W = 6
) (
  input  logic [N-1:0]     act,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (act[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_tally_ctrl.sv
module irq_tally_ctrl #(
  parameter int NUM_LINES = 64,
  parameter int ADDR_W    = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_LINES-1:0]  irq_lines,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic                  irq_out
);
  import irq_tally_pkg::*;

  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam int CNT_W = $clog2(NUM_LINES + 1);
  localparam logic [WORD_W-1:0] A_IDENT  = WORD_W'(W_IDENT);
  localparam logic [WORD_W-1:0] A_COUNT  = WORD_W'(W_COUNT);
  localparam logic [WORD_W-1:0] A_FIRST  = WORD_W'(W_FIRST);
  localparam logic [WORD_W-1:0] A_MALL   = WORD_W'(W_MASK_ALL);
  localparam logic [WORD_W-1:0] A_MONE   = WORD_W'(W_MASK_ONE);
  localparam logic [WORD_W-1:0] A_UNMONE = WORD_W'(W_UNMASK_ONE);

  logic [WORD_W-1:0]    word;
  logic                 wr_hit, rd_hit, idx_ok;
  logic [NUM_LINES-1:0] sel_bit, en_set, en_clr;
  logic                 clr_all;
  logic [NUM_LINES-1:0] en_q, act_q, act_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic                 found;
  logic [IDX_W-1:0]     first_idx;
  logic                 unused_addr;

  assign word        = bus_addr[WIN_W-1:2];
  assign unused_addr = ^{bus_addr[ADDR_W-1:WIN_W], bus_addr[1:0]};
  assign wr_hit      = bus_sel & bus_wr;
  assign rd_hit      = bus_sel & ~bus_wr;
  assign idx_ok      = (bus_wdata < 32'(NUM_LINES));
  assign sel_bit     = {{(NUM_LINES-1){1'b0}}, 1'b1} << bus_wdata[IDX_W-1:0];
  assign en_set      = (wr_hit && word == A_UNMONE && idx_ok) ? sel_bit : '0;
  assign en_clr      = (wr_hit && word == A_MONE && idx_ok) ? sel_bit : '0;
  assign clr_all     = wr_hit && word == A_MALL;

  irq_line_bank #(.N(NUM_LINES)) u_bank (
    .clk(clk), .rst(rst), .irq_lines(irq_lines),
    .en_set(en_set), .en_clr(en_clr), .clr_all(clr_all),
    .en_q(en_q), .act_q(act_q), .act_d(act_d)
  );

  irq_pop_delta #(.N(NUM_LINES), .CNT_W(CNT_W)) u_delta (
    .act_q(act_q), .act_d(act_d), .clr_all(clr_all),
    .cnt_q(cnt_q), .cnt_d(cnt_d)
  );

  irq_lowest_pick #(.N(NUM_LINES), .IDX_W(IDX_W)) u_pick (
    .act(act_q), .found(found), .idx(first_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      irq_out <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      irq_out <= (cnt_d != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_hit) begin
      case (word)
        A_IDENT: bus_rdata <= TALLY_ID;
        A_COUNT: bus_rdata <= 32'(cnt_q);
        A_FIRST: bus_rdata <= found ? 32'(first_idx) : NONE_WORD;
        default: bus_rdata <= '0;
      endcase
    end
  end

  assert_irq_tracks_count_R1: assert property (@(posedge clk) disable iff (rst)
    irq_out == (cnt_q != '0));

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
    int'(cnt_q) <= NUM_LINES);

  assert_count_matches_active_R10: assert property (@(posedge clk) disable iff (rst)
    int'(cnt_q) == $countones(act_q));

  assert_lowest_is_low_R3: assert property (@(posedge clk) disable iff (rst)
    found |-> (act_q[first_idx] &&
               ((act_q & ((NUM_LINES'(1) << first_idx) - NUM_LINES'(1))) == '0)));

  assert_none_means_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !found |-> (act_q == '0));

  assert_enable_sets_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && word == A_UNMONE && idx_ok) |=> en_q[$past(bus_wdata[IDX_W-1:0])]);

  assert_disable_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && word == A_MONE && idx_ok) |=> !en_q[$past(bus_wdata[IDX_W-1:0])]);

  assert_range_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && (word == A_MONE || word == A_UNMONE) && !idx_ok) |=> $stable(en_q));
endmodule

// File: tb/sim_irq_tally_ctrl.sv
module sim_irq_tally_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 64;

  localparam logic [1:0] OP_LINES = 2'd0;
  localparam logic [1:0] OP_WR    = 2'd1;
  localparam logic [1:0] OP_RD    = 2'd2;
  localparam logic [1:0] OP_IRQ   = 2'd3;

  localparam logic [31:0] ID   = 32'h1A7C_0001;
  localparam logic [31:0] NONE = 32'hFFFF_FFFF;
  localparam logic [63:0] L_A  = 64'h0000_0000_0000_0028;
  localparam logic [63:0] L_B  = 64'h0000_0100_0000_0028;
  localparam logic [63:0] L_C  = 64'h0000_0100_0000_0020;
  localparam logic [63:0] L_D  = 64'h0000_0100_0000_0021;
  localparam logic [63:0] L_E  = 64'h8000_0100_0000_0021;

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] addr;
    logic [63:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 56;
  localparam vec_t VEC [NV] = '{
    '{OP_RD,    32'h000, 64'd0,   ID,    4'd8},  // R8 ident
    '{OP_RD,    32'h004, 64'd0,   32'd0, 4'd9},  // R9
    '{OP_RD,    32'h008, 64'd0,   NONE,  4'd3},  // R3 none active
    '{OP_IRQ,   32'h000, 64'd0,   32'd0, 4'd9},
    '{OP_LINES, 32'h000, L_A,     32'd0, 4'd2},  // R2 disabled lines rise
    '{OP_RD,    32'h004, 64'd0,   32'd0, 4'd2},
    '{OP_IRQ,   32'h000, 64'd0,   32'd0, 4'd1},  // R1
    '{OP_WR,    32'h014, 64'd5,   32'd0, 4'd4},  // R4 enable high line
    '{OP_RD,    32'h004, 64'd0,   32'd1, 4'd4},
    '{OP_IRQ,   32'h000, 64'd0,   32'd1, 4'd1},
    '{OP_RD,    32'h008, 64'd0,   32'd5, 4'd3},
    '{OP_WR,    32'h014, 64'd3,   32'd0, 4'd4},
    '{OP_RD,    32'h004, 64'd0,   32'd2, 4'd4},
    '{OP_RD,    32'h008, 64'd0,   32'd3, 4'd3},
    '{OP_WR,    32'h014, 64'd3,   32'd0, 4'd4},  // already enabled
    '{OP_RD,    32'h004, 64'd0,   32'd2, 4'd4},
    '{OP_WR,    32'h014, 64'd40,  32'd0, 4'd4},  // enable low line
    '{OP_RD,    32'h004, 64'd0,   32'd2, 4'd4},
    '{OP_LINES, 32'h000, L_B,     32'd0, 4'd2},  // line 40 rises
    '{OP_RD,    32'h004, 64'd0,   32'd3, 4'd2},
    '{OP_LINES, 32'h000, L_C,     32'd0, 4'd2},  // line 3 falls
    '{OP_RD,    32'h004, 64'd0,   32'd2, 4'd2},
    '{OP_RD,    32'h008, 64'd0,   32'd5, 4'd3},
    '{OP_WR,    32'h010, 64'd5,   32'd0, 4'd5},  // R5 disable high line
    '{OP_RD,    32'h004, 64'd0,   32'd1, 4'd5},
    '{OP_RD,    32'h008, 64'd0,   32'd40, 4'd3},
    '{OP_WR,    32'h010, 64'd5,   32'd0, 4'd5},  // already disabled
    '{OP_RD,    32'h004, 64'd0,   32'd1, 4'd5},
    '{OP_LINES, 32'h000, L_D,     32'd0, 4'd2},  // disabled line 0 rises
    '{OP_RD,    32'h004, 64'd0,   32'd1, 4'd2},
    '{OP_WR,    32'h014, 64'd64,  32'd0, 4'd7},  // R7 would hit line 0
    '{OP_RD,    32'h004, 64'd0,   32'd1, 4'd7},
    '{OP_RD,    32'h008, 64'd0,   32'd40, 4'd7},
    '{OP_WR,    32'h010, 64'd104, 32'd0, 4'd7},  // R7 would hit line 40
    '{OP_RD,    32'h004, 64'd0,   32'd1, 4'd7},
    '{OP_WR,    32'h000, 64'd0,   32'd0, 4'd8},  // R8 write to ident
    '{OP_RD,    32'h000, 64'd0,   ID,    4'd8},
    '{OP_WR,    32'h004, 64'd7,   32'd0, 4'd8},  // write to tally
    '{OP_RD,    32'h004, 64'd0,   32'd1, 4'd8},
    '{OP_RD,    32'h00C, 64'd0,   32'd0, 4'd8},
    '{OP_RD,    32'h010, 64'd0,   32'd0, 4'd8},
    '{OP_RD,    32'h020, 64'd0,   32'd0, 4'd8},
    '{OP_RD,    32'h1008, 64'd0,  32'd40, 4'd8}, // upper address bits masked
    '{OP_WR,    32'h00C, 64'd0,   32'd0, 4'd6},  // R6 disable all
    '{OP_RD,    32'h004, 64'd0,   32'd0, 4'd6},
    '{OP_IRQ,   32'h000, 64'd0,   32'd0, 4'd6},
    '{OP_RD,    32'h008, 64'd0,   NONE,  4'd6},
    '{OP_LINES, 32'h000, L_E,     32'd0, 4'd2},
    '{OP_WR,    32'h014, 64'd63,  32'd0, 4'd4},  // top index
    '{OP_RD,    32'h004, 64'd0,   32'd1, 4'd4},
    '{OP_RD,    32'h008, 64'd0,   32'd63, 4'd3},
    '{OP_LINES, 32'h000, L_D,     32'd0, 4'd2},  // line 63 falls
    '{OP_RD,    32'h004, 64'd0,   32'd0, 4'd2},
    '{OP_WR,    32'h010, 64'd63,  32'd0, 4'd5},  // disable low line, no wrap
    '{OP_RD,    32'h004, 64'd0,   32'd0, 4'd5},
    '{OP_IRQ,   32'h000, 64'd0,   32'd0, 4'd1}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NL-1:0] irq_lines = '0;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq_out;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_tally_ctrl #(.NUM_LINES(NL)) u0 (
    .clk(clk), .rst(rst), .irq_lines(irq_lines),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input int req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_lines(input logic [NL-1:0] v);
    @(negedge clk);
    irq_lines = v;
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(bus_rdata, 32'd0, 9);        // R9 reset read data
    chk({31'd0, irq_out}, 32'd0, 9); // R9 reset interrupt

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        OP_LINES: set_lines(VEC[i].data);
        OP_WR:    do_wr(VEC[i].addr, VEC[i].data[31:0]);
        OP_RD: begin
          do_rd(VEC[i].addr, rd);
          chk(rd, VEC[i].exp, int'(VEC[i].req));
        end
        default: chk({31'd0, irq_out}, VEC[i].exp, int'(VEC[i].req));
      endcase
    end

    // R10: line 7 rises while its enable is written in the same clock
    @(negedge clk);
    irq_lines = L_D | (64'd1 << 7);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 32'h014; bus_wdata = 32'd7;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    do_rd(32'h004, rd); chk(rd, 32'd1, 10);

    // R10: line 7 falls while high line 5 is enabled in the same clock
    @(negedge clk);
    irq_lines = L_D;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 32'h014; bus_wdata = 32'd5;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    do_rd(32'h004, rd); chk(rd, 32'd1, 10);
    do_rd(32'h008, rd); chk(rd, 32'd5, 10);

    // R10: line 5 falls while it is disabled in the same clock
    @(negedge clk);
    irq_lines = 64'h0000_0100_0000_0001;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 32'h010; bus_wdata = 32'd5;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    do_rd(32'h004, rd); chk(rd, 32'd0, 10);
    chk({31'd0, irq_out}, 32'd0, 10);

    // R9: reset in mid-run with a line active
    do_wr(32'h014, 32'd40);
    chk({31'd0, irq_out}, 32'd1, 1);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk({31'd0, irq_out}, 32'd0, 9);
    chk(bus_rdata, 32'd0, 9);
    do_rd(32'h004, rd); chk(rd, 32'd0, 9);
    do_rd(32'h008, rd); chk(rd, NONE, 9);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule